// File: doc/BRIEF.md
# Reset and Boot-Source Capture Sequencer

This block turns an external active-low reset and the "rail good" flags from two supply monitors into the chip's internal reset. The external reset takes effect at once and its release is synchronized to the oscillator clock. The internal reset stays on until both rails have been reported good for a set number of consecutive clock cycles. During reset the oscillator keeps running and the PLL enable is held low.

When the internal reset releases, the block samples four boot-strap pins, holds them, and decodes which boot source to use, flagging codes that are reserved. After a fixed PLL lock wait it sends a single-cycle boot-start pulse. If a rail drops while the device is running, the block enters a graceful shutdown: it asserts the amplifier shutdown for a fixed number of cycles while the clocks stay up, then returns to reset. When the rails are stable again, the same sequence repeats.

All pins are plain control and status levels. There is no data stream and therefore no valid/ready handshake and no back-pressure.

Top module: `rst_boot_seq`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst_n`, `pll_en`, `amp_shutdown`, `boot_start` and `boot_code` are all 0, with no clock edge needed.
- R2: After `ext_rst_n` rises, the internal logic leaves reset on the second clock edge (a two-stage synchronizer). With both rails steadily good, `sys_rst_n` rises on the (STABLE_CYC+5)th edge after the release.
- R3: `sys_rst_n` rises only after both `rail_ok` bits, each passed through a two-stage synchronizer, have been high together for STABLE_CYC consecutive edges. Any low bit restarts the count.
- R4: If a rail drops during the lock wait (reset released, `boot_start` not yet sent), `sys_rst_n` returns low and `amp_shutdown` stays 0.
- R5: If a rail drops while running (after `boot_start`), `amp_shutdown` goes high for exactly SHDN_CYC cycles with `sys_rst_n` still high. Both then go low together.
- R6: `pll_en` is 0 whenever `sys_rst_n` is 0 and rises in the same cycle as `sys_rst_n`.
- R7: `boot_start` is a one-cycle pulse that comes LOCK_CYC cycles after `sys_rst_n` rises, provided the rails stay good.
- R8: `boot_code` takes the value of `strap_pins` at the clock edge on which `sys_rst_n` rises.
- R9: Between two releases of the internal reset, `boot_code` stays the same whatever `strap_pins` do.
- R10: Decode: when `boot_code[3]` is 1 the code is reserved, so `boot_rsvd`=1 and `boot_src`=0. Otherwise `boot_rsvd`=0 and `boot_src`=`boot_code[2:0]`. The source values are 0 I2C memory, 1 SPI memory, 2 I2C target, 3 SPI target, 4 UART, 5 HD audio link, 6 combined I2C memory, 7 combined SPI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, which runs during reset |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| rail_ok | input | 2 | Good flags from the two supply-rail monitors, asynchronous |
| strap_pins | input | 4 | Boot-strap pins, bit 3 selects the reserved range |
| sys_rst_n | output | 1 | Internal reset, active low |
| pll_en | output | 1 | PLL enable |
| amp_shutdown | output | 1 | Safe amplifier shutdown command |
| boot_start | output | 1 | One-cycle pulse that starts the boot |
| boot_code | output | 4 | Captured strap value |
| boot_src | output | 3 | Decoded boot source |
| boot_rsvd | output | 1 | Captured code is reserved |

## Verification
Each result has a known latency. Reset assertion reaches the outputs at once. A rail change is seen at `sys_rst_n` or `amp_shutdown` three edges later (two synchronizer stages plus the stability counter), and one more edge later when it triggers a state change. `boot_code` and its decode change on the same edge as `sys_rst_n` rises, and `boot_start` comes LOCK_CYC edges after that. Inputs change 1 ns after a rising edge. A behavioural model advances on the same rising edge, and every output is compared with it at the falling edge, so each latency is checked in exactly the cycle it is due.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    ST_RESET    = 2'd0,
    ST_LOCKWAIT = 2'd1,
    ST_RUN      = 2'd2,
    ST_SHUTDOWN = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    SRC_I2C_MEM   = 3'd0,
    SRC_SPI_MEM   = 3'd1,
    SRC_I2C_TGT   = 3'd2,
    SRC_SPI_TGT   = 3'd3,
    SRC_UART      = 3'd4,
    SRC_HDAUDIO   = 3'd5,
    SRC_COMBO_I2C = 3'd6,
    SRC_COMBO_SPI = 3'd7
  } boot_src_e;

  // Bit 3 of the strap code marks the reserved half of the code space.
  function automatic boot_src_e decode_strap(input logic [3:0] code);
    boot_src_e s;
    if (code[3]) begin
      s = SRC_I2C_MEM;
    end else begin
      unique case (code[2:0])
        3'd0:    s = SRC_I2C_MEM;
        3'd1:    s = SRC_SPI_MEM;
        3'd2:    s = SRC_I2C_TGT;
        3'd3:    s = SRC_SPI_TGT;
        3'd4:    s = SRC_UART;
        3'd5:    s = SRC_HDAUDIO;
        3'd6:    s = SRC_COMBO_I2C;
        default: s = SRC_COMBO_SPI;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/rbs_rst_sync.sv
module rbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  // Assertion is asynchronous, release walks through the chain.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rbs_rail_qual.sv
module rbs_rail_qual #(
  parameter int NUM_RAILS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RAILS-1:0] rail_ok,
  output logic                 pwr_good
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(STABLE_CYC);

  logic [NUM_RAILS-1:0] ok_s;
  logic                 all_ok;
  logic [CW-1:0]        stab_q;

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    logic [SYNC_STAGES-1:0] sq;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq <= '0;
      else        sq <= {sq[SYNC_STAGES-2:0], rail_ok[r]};
    end
    assign ok_s[r] = sq[SYNC_STAGES-1];
  end

  assign all_ok = &ok_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stab_q <= '0;
    else if (!all_ok)        stab_q <= '0;
    else if (stab_q != CNT_MAX) stab_q <= stab_q + 1'b1;
  end

  assign pwr_good = (stab_q == CNT_MAX);

  assert_dip_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !all_ok |=> !pwr_good);
  assert_good_needs_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> $past(all_ok));
endmodule

// File: rtl/rbs_boot_latch.sv
module rbs_boot_latch
  import rbs_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CODE_W-1:0] pins,
  output logic [CODE_W-1:0] code,
  output logic [2:0]        src,
  output logic              rsvd
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (capture) code_q <= pins;
  end

  assign code = code_q;
  assign src  = decode_strap(code_q);
  assign rsvd = code_q[CODE_W-1];

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> code == $past(pins));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(code));
endmodule

// File: rtl/rst_boot_seq.sv
module rst_boot_seq
  import rbs_pkg::*;
#(
  parameter int STABLE_CYC = 16,
  parameter int LOCK_CYC   = 8,
  parameter int SHDN_CYC   = 4
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic [1:0] rail_ok,
  input  logic [3:0] strap_pins,
  output logic       sys_rst_n,
  output logic       pll_en,
  output logic       amp_shutdown,
  output logic       boot_start,
  output logic [3:0] boot_code,
  output logic [2:0] boot_src,
  output logic       boot_rsvd
);
  localparam int SYNC_STAGES = 2;
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam int SW = $clog2(SHDN_CYC + 1);
  localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_CYC - 1);
  localparam logic [SW-1:0] SHDN_LAST = SW'(SHDN_CYC - 1);

  logic          rrst_n;
  logic          pwr_good;
  logic          capture;
  seq_state_e    st_q;
  logic [LW-1:0] lock_q;
  logic [SW-1:0] shdn_q;
  logic          start_q;

  rbs_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .arst_n(ext_rst_n), .srst_n(rrst_n)
  );

  rbs_rail_qual #(
    .NUM_RAILS(2), .SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC)
  ) u_rail (
    .clk(clk), .rst_n(rrst_n), .rail_ok(rail_ok), .pwr_good(pwr_good)
  );

  assign capture = (st_q == ST_RESET) && pwr_good;

  rbs_boot_latch #(.CODE_W(4)) u_boot (
    .clk(clk), .rst_n(rrst_n), .capture(capture), .pins(strap_pins),
    .code(boot_code), .src(boot_src), .rsvd(boot_rsvd)
  );

  always_ff @(posedge clk or negedge rrst_n) begin
    if (!rrst_n) begin
      st_q    <= ST_RESET;
      lock_q  <= '0;
      shdn_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (st_q)
        ST_RESET: begin
          if (pwr_good) begin
            st_q   <= ST_LOCKWAIT;
            lock_q <= '0;
          end
        end
        ST_LOCKWAIT: begin
          if (!pwr_good) begin
            st_q <= ST_RESET;
          end else if (lock_q == LOCK_LAST) begin
            st_q    <= ST_RUN;
            start_q <= 1'b1;
          end else begin
            lock_q <= lock_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (!pwr_good) begin
            st_q   <= ST_SHUTDOWN;
            shdn_q <= '0;
          end
        end
        ST_SHUTDOWN: begin
          if (shdn_q == SHDN_LAST) st_q <= ST_RESET;
          else                     shdn_q <= shdn_q + 1'b1;
        end
        default: st_q <= ST_RESET;
      endcase
    end
  end

  assign sys_rst_n    = (st_q != ST_RESET);
  assign pll_en       = (st_q != ST_RESET);
  assign amp_shutdown = (st_q == ST_SHUTDOWN);
  assign boot_start   = start_q;

  assert_hold_in_reset_R3: assert property (@(posedge clk) disable iff (!rrst_n)
    (!sys_rst_n && !pwr_good) |=> !sys_rst_n);
  assert_lock_dropout_R4: assert property (@(posedge clk) disable iff (!rrst_n)
    (sys_rst_n && !amp_shutdown && !pwr_good && !boot_start && st_q == ST_LOCKWAIT)
      |=> (!sys_rst_n && !amp_shutdown));
  assert_droop_shutdown_R5: assert property (@(posedge clk) disable iff (!rrst_n)
    (st_q == ST_RUN && !pwr_good) |=> (amp_shutdown && sys_rst_n));
  assert_pll_with_start_R6: assert property (@(posedge clk) disable iff (!rrst_n)
    boot_start |-> pll_en);
  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rrst_n)
    boot_start |=> !boot_start);
  assert_code_on_release_R8: assert property (@(posedge clk) disable iff (!rrst_n)
    $rose(sys_rst_n) |-> boot_code == $past(strap_pins));
endmodule

// File: tb/sim_rst_boot_seq.sv
module sim_rst_boot_seq;
  localparam int STABLE_CYC = 16;
  localparam int LOCK_CYC   = 8;
  localparam int SHDN_CYC   = 4;

  logic       clk = 1'b0;
  logic       ext_rst_n = 1'b0;
  logic [1:0] rail_ok = 2'b11;
  logic [3:0] strap_pins = 4'b0101;
  logic       sys_rst_n, pll_en, amp_shutdown, boot_start, boot_rsvd;
  logic [3:0] boot_code;
  logic [2:0] boot_src;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rst_boot_seq #(.STABLE_CYC(STABLE_CYC), .LOCK_CYC(LOCK_CYC), .SHDN_CYC(SHDN_CYC)) u0 (
    .clk(clk), .ext_rst_n(ext_rst_n), .rail_ok(rail_ok), .strap_pins(strap_pins),
    .sys_rst_n(sys_rst_n), .pll_en(pll_en), .amp_shutdown(amp_shutdown),
    .boot_start(boot_start), .boot_code(boot_code), .boot_src(boot_src),
    .boot_rsvd(boot_rsvd)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Behavioural reference: timing counted from the requirements.
  bit m_s1, m_s2, m_ok1, m_ok2, m_bs;
  int m_cnt, m_st, m_lk, m_sh;
  logic [3:0] m_code;
  bit pre_rr, pre_ok2, good;

  always @(posedge clk) begin
    cyc++;
    if (!ext_rst_n) begin
      m_s1 = 0; m_s2 = 0; m_ok1 = 0; m_ok2 = 0; m_bs = 0;
      m_cnt = 0; m_st = 0; m_lk = 0; m_sh = 0; m_code = '0;
    end else begin
      pre_rr  = m_s2;
      pre_ok2 = m_ok2;
      good    = (m_cnt == STABLE_CYC);
      if (!pre_rr) begin
        m_ok1 = 0; m_ok2 = 0; m_bs = 0;
        m_cnt = 0; m_st = 0; m_lk = 0; m_sh = 0; m_code = '0;
      end else begin
        m_cnt = !pre_ok2 ? 0 : (m_cnt < STABLE_CYC ? m_cnt + 1 : m_cnt);
        m_ok2 = m_ok1;
        m_ok1 = rail_ok[0] && rail_ok[1];
        m_bs  = 0;
        case (m_st)
          0: if (good) begin m_st = 1; m_lk = 0; m_code = strap_pins; end
          1: if (!good) m_st = 0;
             else if (m_lk == LOCK_CYC - 1) begin m_st = 2; m_bs = 1; end
             else m_lk++;
          2: if (!good) begin m_st = 3; m_sh = 0; end
          default: if (m_sh == SHDN_CYC - 1) m_st = 0; else m_sh++;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (!ext_rst_n) begin
        check("R1", "sys_rst_n", sys_rst_n, 0);
        check("R1", "pll_en", pll_en, 0);
        check("R1", "amp_shutdown", amp_shutdown, 0);
        check("R1", "boot_start", boot_start, 0);
        check("R1", "boot_code", boot_code, 0);
      end else begin
        check("R3", "sys_rst_n", sys_rst_n, int'(m_st != 0));
        check("R6", "pll_en", pll_en, int'(m_st != 0));
        check("R5", "amp_shutdown", amp_shutdown, int'(m_st == 3));
        check("R7", "boot_start", boot_start, int'(m_bs));
        check("R8", "boot_code", boot_code, int'(m_code));
        check("R10", "boot_rsvd", boot_rsvd, int'(m_code[3]));
        check("R10", "boot_src", boot_src, m_code[3] ? 0 : int'(m_code[2:0]));
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_rst(input bit lvl, output int n);
    n = 0;
    while (sys_rst_n !== lvl && n < 500) begin
      step(1);
      n++;
    end
  endtask

  task automatic droop_and_reboot(input logic [3:0] pins);
    int n;
    strap_pins = pins;
    rail_ok[0] = 1'b0;
    step(1);
    rail_ok[0] = 1'b1;
    wait_rst(1'b0, n);
    wait_rst(1'b1, n);
    step(LOCK_CYC + 2);
  endtask

  initial begin
    int n;
    logic [3:0] held;
    step(3);
    check("R1", "sys_rst_n in reset", sys_rst_n, 0);
    ext_rst_n = 1'b1;
    wait_rst(1'b1, n);
    check("R2", "edges to release", n, STABLE_CYC + 5);
    step(LOCK_CYC + 2);
    check("R10", "boot_src for 0101", boot_src, 5);

    strap_pins = 4'b1111;
    held = boot_code;
    step(6);
    check("R9", "code held after pin change", boot_code, held);

    strap_pins = 4'b1010;
    rail_ok[0] = 1'b0;
    step(1);
    rail_ok[0] = 1'b1;
    n = 0;
    while (!amp_shutdown && n < 50) begin step(1); n++; end
    n = 0;
    while (amp_shutdown && n < 50) begin
      check("R5", "reset held during shutdown", sys_rst_n, 1);
      step(1); n++;
    end
    check("R5", "shutdown length", n, SHDN_CYC);
    wait_rst(1'b1, n);
    step(1);
    check("R8", "captured code", boot_code, 4'b1010);
    check("R10", "reserved flag", boot_rsvd, 1);

    // brown-out during lock wait
    step(LOCK_CYC + 2);
    droop_and_reboot(4'b0011);
    rail_ok[0] = 1'b0; step(1); rail_ok[0] = 1'b1;
    wait_rst(1'b0, n);
    wait_rst(1'b1, n);
    step(1);
    rail_ok[1] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check("R4", "no shutdown in lock wait", amp_shutdown, 0);
      step(1);
    end
    check("R4", "back in reset", sys_rst_n, 0);
    rail_ok[1] = 1'b1;
    wait_rst(1'b1, n);
    step(LOCK_CYC + 2);

    // rail flicker restarts qualification
    ext_rst_n = 1'b0;
    step(2);
    ext_rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step(10);
      rail_ok[1] = 1'b0; step(1); rail_ok[1] = 1'b1;
    end
    step(STABLE_CYC - 2);
    check("R3", "still in reset after flicker", sys_rst_n, 0);
    wait_rst(1'b1, n);
    step(LOCK_CYC + 2);

    // every strap code
    for (int c = 0; c < 16; c++) begin
      droop_and_reboot(4'(c));
      check("R10", "decode src", boot_src, c[3] ? 0 : c % 8);
      check("R10", "decode rsvd", boot_rsvd, c / 8);
    end

    // asynchronous reset mid-run
    ext_rst_n = 1'b0;
    #1;
    check("R1", "immediate reset", sys_rst_n, 0);
    check("R1", "immediate code clear", boot_code, 0);
    step(4);
    done = 1'b1;
    finish_run();
  end
endmodule